// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Interlock

This block recovers asynchronous serial frames from a single receive line. It is clocked by the system clock and advances on a base-clock enable that pulses 16 times per bit period. It locks its bit timing to the falling edge that opens each frame and samples every bit once, near the middle of that bit. The recovered character, a data-ready flag and three sticky error flags are held until a consumer reads or clears them. The error flags cover overrun, parity and framing.

A small gate also produces a transmit-permit signal. In synchronous mode this signal is withheld while any receive error flag is set, even when the transmit buffer reports empty. This means software must clear the receive errors before transmission can start. Disabling the receiver abandons any frame in progress but leaves the error flags untouched.

Top module: `oversampled_rx`

## Requirements
- R1: A bit period is 16 base ticks. In idle, a tick that samples `rxd` as 0 after a tick that sampled it as 1 is the frame's detection tick. Bit k of the frame is sampled on the 7th tick after the detection tick plus 16·k ticks, where the start bit is k = 0.
- R2: Data bits arrive LSB first. With `fmt_seven` = 0 there are 8 data bits. With `fmt_seven` = 1 there are 7, and `rx_data[7]` reads 0. A completed frame loads `rx_data` and sets `rx_ready`. A one-cycle `rd_strobe` clears `rx_ready` on the next clock.
- R3: With `par_en` = 1, one parity bit follows the data. With `par_odd` = 0, the data bits plus the parity bit must hold an even number of ones; with `par_odd` = 1, an odd number. A mismatch sets `err_parity`.
- R4: A stop bit sampled as 0 sets `err_framing`. With `two_stop` = 1, two stop bits are sampled and either one being low sets it.
- R5: If the start bit's sample reads 1, the receiver returns to idle. It sets no flag and produces no data.
- R6: A frame is received correctly when every internal bit edge is displaced by up to 7 ticks, early or late, from its nominal position.
- R7: When a frame completes while `rx_ready` is still 1 and no read is strobed in that cycle, `err_overrun` is set. `rx_data`, `err_parity` and `err_framing` keep their values.
- R8: `tx_permit` equals `tx_empty`, except that it is forced to 0 when `sync_mode` = 1 and any error flag is 1.
- R9: Each error flag is sticky. Only its own clear strobe clears it. Clearing `rx_en` does not clear it. A set in the same cycle as its clear wins.
- R10: While `rx_en` = 0, the receiver is held idle. A frame in progress is discarded without setting `rx_ready` or any flag.
- R11: After reset, `rx_data`, `rx_ready` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base-clock enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable |
| fmt_seven | input | 1 | 1: seven data bits, 0: eight |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even |
| two_stop | input | 1 | 1: two stop bits |
| sync_mode | input | 1 | Enables the error interlock on transmit permit |
| tx_empty | input | 1 | Transmit buffer empty indication |
| clr_overrun | input | 1 | Clear strobe for the overrun flag |
| clr_parity | input | 1 | Clear strobe for the parity flag |
| clr_framing | input | 1 | Clear strobe for the framing flag |
| rd_strobe | input | 1 | Data-read strobe, clears data-ready |
| rx_data | output | 8 | Last accepted character |
| rx_ready | output | 1 | Data-ready flag |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity-error flag |
| err_framing | output | 1 | Sticky framing-error flag |
| tx_permit | output | 1 | Transmit may start |

## Verification
The assertions take for granted that the format controls stay constant from the detection tick to frame completion. They also assume `tick_en` is a single-cycle pulse, so that at most one sample is taken per tick. The stimulus changes the format only between frames, with the line idle. It derives `tick_en` from a free-running divider and changes `rxd` only on the clock edge just before a tick, so each line level lasts a whole number of ticks. The read and clear strobes are single cycles, and except in the set-versus-clear case they are kept away from frame completion.

// File: rtl/rx_pkg.sv
// Shared types for the oversampled receiver.
// Assumes an 8-bit maximum character width at the top level.
package rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_bad;
        logic       stop_bad;
    } frame_res_t;

endpackage

// File: rtl/rx_frame_seq.sv
// Frame sequencer: detects the start edge on the base-clock enable, counts
// OSR ticks per bit and samples each bit at the nominal centre. It emits a
// one-cycle done pulse with the character and per-frame error results.
// Assumes: format inputs are stable during a frame; tick is one cycle wide.
module rx_frame_seq
    import rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       short_char,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       done,
    output frame_res_t res
);
    localparam int CW        = $clog2(OSR);
    localparam int IW        = $clog2(DW);
    localparam int SAMPLE_AT = OSR / 2 - 1;

    rx_state_e     st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bit_idx;
    logic          stop_idx;
    logic          prev_rxd;
    logic [DW-1:0] sh;
    logic          par_acc;
    logic          stop_bad_q;
    logic          samp;
    logic [IW-1:0] last_idx;

    // Sample strobe: the tick on which the current bit is at its centre.
    always_comb samp = tick && (cnt == CW'(SAMPLE_AT));

    // Index of the final data bit for the selected character length.
    always_comb last_idx = short_char ? IW'(DW - 2) : IW'(DW - 1);

    // Sequencer state, tick counter, shift register and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            stop_idx   <= 1'b0;
            prev_rxd   <= 1'b1;
            sh         <= '0;
            par_acc    <= 1'b0;
            stop_bad_q <= 1'b0;
            done       <= 1'b0;
            res        <= '0;
        end else begin
            done <= 1'b0;
            if (tick) prev_rxd <= rxd;
            if (!rx_en) begin
                st <= ST_IDLE;
            end else if (tick) begin
                if (st != ST_IDLE) cnt <= cnt + 1'b1;
                unique case (st)
                    ST_IDLE: begin
                        if (prev_rxd && !rxd) begin
                            st  <= ST_START;
                            cnt <= CW'(1);
                        end
                    end
                    ST_START: begin
                        if (samp) begin
                            if (rxd) begin
                                st <= ST_IDLE;
                            end else begin
                                st         <= ST_DATA;
                                bit_idx    <= '0;
                                par_acc    <= 1'b0;
                                stop_bad_q <= 1'b0;
                                stop_idx   <= 1'b0;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (samp) begin
                            sh      <= {rxd, sh[DW-1:1]};
                            par_acc <= par_acc ^ rxd;
                            if (bit_idx == last_idx) begin
                                st <= par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (samp) begin
                            par_acc <= par_acc ^ rxd;
                            st      <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (samp) begin
                            if (two_stop && !stop_idx) begin
                                stop_idx   <= 1'b1;
                                stop_bad_q <= stop_bad_q | !rxd;
                            end else begin
                                st           <= ST_IDLE;
                                done         <= 1'b1;
                                res.data     <= short_char ? 8'(sh >> 1) : 8'(sh);
                                res.par_bad  <= par_en & (par_acc ^ par_odd);
                                res.stop_bad <= stop_bad_q | !rxd;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R5
    glitch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && st == ST_START && samp && rxd) |=> (st == ST_IDLE && !done));

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (st == ST_IDLE && !done));

endmodule

// File: rtl/rx_status.sv
// Receive status holder: the data buffer, data-ready flag and the three
// sticky error flags. Flags are changed only by frame completion (set) and
// their own clear strobes. Assumes done is a single-cycle pulse.
module rx_status
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  frame_res_t res,
    input  logic       rd_strobe,
    input  logic       clr_ovr,
    input  logic       clr_per,
    input  logic       clr_fer,
    output logic [7:0] data,
    output logic       ready,
    output logic       ovr,
    output logic       per,
    output logic       fer
);
    logic busy;
    logic load;
    logic set_ovr;

    // A read in the completion cycle frees the buffer for the new frame.
    always_comb begin
        busy    = ready && !rd_strobe;
        load    = done && !busy;
        set_ovr = done && busy;
    end

    // Buffer, ready flag and sticky flags; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            per   <= 1'b0;
            fer   <= 1'b0;
        end else begin
            if (load) data <= res.data;
            ready <= (ready && !rd_strobe) || load;
            ovr   <= (ovr && !clr_ovr) || set_ovr;
            per   <= (per && !clr_per) || (load && res.par_bad);
            fer   <= (fer && !clr_fer) || (load && res.stop_bad);
        end
    end

    // R7
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready && !rd_strobe) |=> (ovr && $stable(data)));

    // R9
    per_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per && !clr_per) |=> per);

    // R9
    fer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fer && !clr_fer) |=> fer);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_ovr) |=> ovr);

endmodule

// File: rtl/tx_gate.sv
// Transmit-start gate: passes the buffer-empty indication, blocking it in
// synchronous mode while any receive error is pending. Purely combinational.
module tx_gate (
    input  logic sync_mode,
    input  logic tx_empty,
    input  logic ovr,
    input  logic per,
    input  logic fer,
    output logic permit
);
    // Interlock: any pending receive error blocks transmit start when synchronous.
    always_comb permit = tx_empty && !(sync_mode && (ovr || per || fer));
endmodule

// File: rtl/oversampled_rx.sv
// Top level: oversampled serial receiver with the transmit-start interlock.
// Assumes tick_en pulses OSR times per bit and rxd idles high.
module oversampled_rx
    import rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       fmt_seven,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       sync_mode,
    input  logic       tx_empty,
    input  logic       clr_overrun,
    input  logic       clr_parity,
    input  logic       clr_framing,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       err_framing,
    output logic       tx_permit
);
    logic       done;
    frame_res_t res;

    rx_frame_seq #(.OSR(OSR), .DW(8)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .rxd        (rxd),
        .rx_en      (rx_en),
        .short_char (fmt_seven),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .two_stop   (two_stop),
        .done       (done),
        .res        (res)
    );

    rx_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .res       (res),
        .rd_strobe (rd_strobe),
        .clr_ovr   (clr_overrun),
        .clr_per   (clr_parity),
        .clr_fer   (clr_framing),
        .data      (rx_data),
        .ready     (rx_ready),
        .ovr       (err_overrun),
        .per       (err_parity),
        .fer       (err_framing)
    );

    tx_gate gate_i (
        .sync_mode (sync_mode),
        .tx_empty  (tx_empty),
        .ovr       (err_overrun),
        .per       (err_parity),
        .fer       (err_framing),
        .permit    (tx_permit)
    );

    // R8
    permit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && (err_overrun || err_parity || err_framing)) |-> !tx_permit);

endmodule

// File: tb/oversampled_rx_tb_top.sv
// Scoreboard bench: the frame driver queues expected characters, a monitor
// compares them when data-ready rises.
module oversampled_rx_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, rxd = 1'b1, rx_en = 1'b0;
    logic       fmt_seven = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       sync_mode = 1'b1, tx_empty = 1'b1;
    logic       clr_o_tb = 1'b0, clr_p_tb = 1'b0, clr_f_tb = 1'b0, rd_tb = 1'b0;
    logic       mon_rd = 1'b0, mon_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_overrun, err_parity, err_framing, tx_permit;
    logic [1:0] div = 2'd0;
    logic       tick_en;

    always_ff @(posedge clk) div <= div + 2'd1;
    assign tick_en = (div == 2'd0);

    oversampled_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rxd(rxd), .rx_en(rx_en),
        .fmt_seven(fmt_seven), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .sync_mode(sync_mode), .tx_empty(tx_empty),
        .clr_overrun(clr_o_tb | mon_clr), .clr_parity(clr_p_tb | mon_clr),
        .clr_framing(clr_f_tb | mon_clr), .rd_strobe(rd_tb | mon_rd),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_overrun(err_overrun),
        .err_parity(err_parity), .err_framing(err_framing), .tx_permit(tx_permit)
    );

    int    n_chk = 0, n_bad = 0;
    bit    ended = 1'b0;
    bit    auto_ack = 1'b1;
    bit    keep_p = 1'b0;
    string cur_req = "R1 R2";

    typedef struct { logic [7:0] d; logic p; logic f; } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per rising data-ready, then optionally acks.
    logic rdy_d = 1'b0;
    always @(negedge clk) begin
        mon_rd  = 1'b0;
        mon_clr = 1'b0;
        if (rst_n && rx_ready && !rdy_d) begin
            if (sb_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected character", rx_data, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rx_data == e.d, cur_req, "rx_data", rx_data, e.d);
                check(err_parity == e.p, cur_req, "err_parity", err_parity, e.p);
                check(err_framing == e.f, cur_req, "err_framing", err_framing, e.f);
                if (auto_ack) begin
                    mon_rd  = 1'b1;
                    mon_clr = 1'b1;
                end
            end
        end
        rdy_d = rx_ready;
    end

    // Advance to the falling edge just before the next tick.
    task automatic wait_tick();
        do @(negedge clk); while (!tick_en);
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic send(input logic [7:0] d, input bit seven, input bit pen,
                        input bit podd, input bit two, input bit bad_par,
                        input bit bad_stop, input int skew, input bit push);
        int   nb;
        logic pbit;
        exp_t e;
        fmt_seven = seven; par_en = pen; par_odd = podd; two_stop = two;
        nb = seven ? 7 : 8;
        pbit = podd;
        for (int i = 0; i < nb; i++) pbit ^= d[i];
        if (push) begin
            e.d = seven ? (d & 8'h7F) : d;
            e.p = (pen & bad_par) | keep_p;
            e.f = bad_stop;
            sb_q.push_back(e);
        end
        hold(1'b0, 16 + skew);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (pen) hold(pbit ^ bad_par, 16);
        if (two) hold(1'b1, 16);
        hold(!bad_stop, 16 - skew);
        hold(1'b1, 16);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_tb = 1'b1;
        @(negedge clk) rd_tb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state; R8 permit with no errors
        check(rx_ready == 1'b0, "R11", "rx_ready", rx_ready, 0);
        check(rx_data == 8'h00, "R11", "rx_data", rx_data, 0);
        check({err_overrun, err_parity, err_framing} == 3'b000, "R11", "flags",
              {err_overrun, err_parity, err_framing}, 0);
        check(tx_permit == 1'b1, "R8", "tx_permit clean", tx_permit, 1);
        rst_n = 1'b1;
        rx_en = 1'b1;
        wait_tick();
        hold(1'b1, 20);

        // R1 R2 plain 8-bit frames, LSB first
        cur_req = "R1 R2";
        send(8'h55, 0, 0, 0, 0, 0, 0, 0, 1);
        send(8'hA3, 0, 0, 0, 0, 0, 0, 0, 1);
        send(8'h00, 0, 0, 0, 0, 0, 0, 0, 1);
        send(8'hFF, 0, 0, 0, 0, 0, 0, 0, 1);
        send(8'hF1, 1, 0, 0, 0, 0, 0, 0, 1);

        // R3 parity, both senses, good and bad; R4 two stop bits
        cur_req = "R3";
        send(8'h5A, 1, 1, 0, 0, 0, 0, 0, 1);
        send(8'h37, 0, 1, 1, 1, 0, 0, 0, 1);
        send(8'hC4, 0, 1, 0, 0, 1, 0, 0, 1);
        send(8'h2B, 1, 1, 1, 0, 1, 0, 0, 1);

        // R4 framing errors with one and two stop bits
        cur_req = "R4";
        send(8'h81, 0, 0, 0, 0, 0, 1, 0, 1);
        send(8'h18, 0, 1, 0, 1, 0, 1, 0, 1);

        // R6 internal edges displaced late and early by 7 ticks
        cur_req = "R6";
        send(8'h96, 0, 1, 0, 0, 0, 0, 7, 1);
        send(8'h69, 0, 0, 0, 1, 0, 0, -7, 1);

        // R5 short start glitch is dropped silently
        cur_req = "R5";
        hold(1'b0, 5);
        hold(1'b1, 40);
        check(rx_ready == 1'b0, "R5", "rx_ready after glitch", rx_ready, 0);
        check({err_overrun, err_parity, err_framing} == 3'b000, "R5", "flags after glitch",
              {err_overrun, err_parity, err_framing}, 0);
        send(8'hE7, 0, 0, 0, 0, 0, 0, 0, 1);
        check(sb_q.size() == 0, "R5", "queue drained", sb_q.size(), 0);

        // R7 overrun keeps the first character
        cur_req = "R7";
        auto_ack = 1'b0;
        send(8'h3C, 0, 0, 0, 0, 0, 0, 0, 1);
        send(8'hC3, 0, 0, 0, 0, 0, 1, 0, 0);
        check(rx_ready == 1'b1, "R7", "rx_ready held", rx_ready, 1);
        check(rx_data == 8'h3C, "R7", "rx_data kept", rx_data, 8'h3C);
        check(err_overrun == 1'b1, "R7", "err_overrun", err_overrun, 1);
        check(err_framing == 1'b0, "R7", "err_framing untouched", err_framing, 0);

        // R8 interlock in synchronous mode only
        check(tx_permit == 1'b0, "R8", "tx_permit blocked", tx_permit, 0);
        sync_mode = 1'b0;
        @(negedge clk);
        check(tx_permit == 1'b1, "R8", "tx_permit async", tx_permit, 1);
        sync_mode = 1'b1;
        tx_empty  = 1'b0;
        @(negedge clk);
        check(tx_permit == 1'b0, "R8", "tx_permit not empty", tx_permit, 0);
        tx_empty = 1'b1;

        // R9 flags survive disable and clear only by own strobe
        rx_en = 1'b0;
        hold(1'b1, 4);
        check(err_overrun == 1'b1, "R9", "overrun after disable", err_overrun, 1);
        @(negedge clk) clr_o_tb = 1'b1;
        @(negedge clk) clr_o_tb = 1'b0;
        check(err_overrun == 1'b0, "R9", "overrun cleared", err_overrun, 0);
        check(tx_permit == 1'b1, "R8", "tx_permit after clear", tx_permit, 1);
        pulse_rd();
        check(rx_ready == 1'b0, "R2", "rx_ready after read", rx_ready, 0);

        rx_en = 1'b1;
        cur_req = "R9";
        send(8'h4D, 0, 1, 0, 0, 1, 0, 0, 1);
        pulse_rd();
        keep_p = 1'b1;
        send(8'hB2, 0, 0, 0, 0, 0, 1, 0, 1);
        keep_p = 1'b0;
        pulse_rd();
        rx_en = 1'b0;
        hold(1'b1, 4);
        check(err_parity == 1'b1, "R9", "parity after disable", err_parity, 1);
        check(err_framing == 1'b1, "R9", "framing after disable", err_framing, 1);
        @(negedge clk) clr_p_tb = 1'b1;
        @(negedge clk) clr_p_tb = 1'b0;
        check(err_parity == 1'b0, "R9", "parity cleared", err_parity, 0);
        check(err_framing == 1'b1, "R9", "framing kept", err_framing, 1);
        @(negedge clk) clr_f_tb = 1'b1;
        @(negedge clk) clr_f_tb = 1'b0;
        check(err_framing == 1'b0, "R9", "framing cleared", err_framing, 0);

        // R10 disable mid-frame discards the partial frame
        cur_req = "R10";
        auto_ack = 1'b1;
        rx_en = 1'b1;
        wait_tick();
        hold(1'b0, 16);
        hold(1'b1, 16);
        rx_en = 1'b0;
        for (int i = 0; i < 7; i++) hold(1'b0, 16);
        hold(1'b1, 16);
        hold(1'b1, 16);
        rx_en = 1'b1;
        hold(1'b1, 8);
        check(rx_ready == 1'b0, "R10", "no data after abort", rx_ready, 0);
        check({err_overrun, err_parity, err_framing} == 3'b000, "R10", "no flags after abort",
              {err_overrun, err_parity, err_framing}, 0);
        send(8'h7E, 0, 0, 0, 0, 0, 0, 0, 1);
        hold(1'b1, 8);
        check(sb_q.size() == 0, "R10", "queue drained", sb_q.size(), 0);
        finish_run();
    end
endmodule